// File: doc/BRIEF.md
# Ring Oscillator Response Measurement Controller

This block runs one measurement of a bank of ring-oscillator counters and turns the result into a response word. Each oscillator clocks its own up-counter. A start command clears every counter and then raises one shared enable. One oscillator is chosen as the timebase by configuration. Counting stops when that oscillator's counter equals an observation count supplied by the authenticator, so the block needs no absolute clock reference for timing.

After the stop, the controller waits for a settle interval. It then reads the frozen counters in the system clock domain. An address vector picks several counters, and each one is compared with the timebase counter on the same die to give one response bit. Both counts drift together with temperature and supply, so the comparison cancels that drift. The oscillator inputs are edge sources only. The analog rings and any post-processing of the response are outside this block.

Top module: `ro_meas_ctrl`

## Requirements
- R1: After reset, `ready`, `run_en` and `response` are all 0.
- R2: An accepted `start` clears every counter before `run_en` rises, so no count carries over from an earlier measurement.
- R3: Each channel counter advances on rising edges of its own `osc_clk` bit, and only while `run_en` is high.
- R4: The timebase counter selected by `ref_sel` stops exactly at `obs_count` and never exceeds it.
- R5: `run_en` falls only after the timebase count has reached `obs_count` and that event has passed a two-flop synchronizer. `ready` rises after a further two-cycle settle interval.
- R6: Response bit k is 1 when the counter addressed by `addr[k*SEL_W +: SEL_W]` is strictly greater than the timebase counter, and 0 otherwise. A slot that addresses the timebase channel itself therefore reads 0.
- R7: A `start` that arrives while a measurement is in progress (clear, counting or settle) is ignored, and the measurement continues.
- R8: Once `ready` is high, it and `response` stay unchanged until the next accepted `start`.
- R9: With `obs_count` equal to 0, the measurement still completes and every slot that addresses the timebase channel reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | NUM_OSC | One rising-edge source per ring oscillator |
| start | input | 1 | Single-cycle pulse that requests a measurement |
| obs_count | input | CNT_W | Observation count for the timebase counter |
| ref_sel | input | SEL_W | Index of the timebase oscillator |
| addr | input | RESP_BITS*SEL_W | Counter index for each response slot, slot k at bits k*SEL_W |
| run_en | output | 1 | Shared oscillator and counter enable |
| ready | output | 1 | Response valid and block idle |
| response | output | RESP_BITS | Comparison bits, one per slot |

## Verification
The bench builds the block with four oscillators, four response slots and 10-bit counters. At that size it can sweep every timebase choice against every slot rotation and two observation counts. The four oscillator periods are fixed and clearly distinct, so each expected bit is simply whether the addressed oscillator is faster than the timebase. Running the long observation count before the short one shows that the counters are cleared between measurements. The zero observation count and a start pulse in the middle of a measurement are checked as separate cases.

// File: rtl/ro_meas_pkg.sv
`timescale 1ns/1ps
package ro_meas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_RUN    = 3'd2,
    ST_SETTLE = 3'd3,
    ST_DONE   = 3'd4
  } meas_state_t;

  localparam int unsigned MAX_CNT_W = 64;

  // one response bit: strictly faster than the timebase gives 1
  function automatic logic beats_ref(input logic [MAX_CNT_W-1:0] sel_cnt,
                                     input logic [MAX_CNT_W-1:0] ref_cnt);
    return sel_cnt > ref_cnt;
  endfunction

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ro_cnt_channel.sv
`timescale 1ns/1ps
module ro_cnt_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             osc_i,
  input  logic             clr_i,
  input  logic             run_en_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o
);

  // counts in the oscillator's own domain; clear comes from the controller
  always_ff @(posedge osc_i or posedge clr_i) begin
    if (clr_i)                     cnt_o <= '0;
    else if (run_en_i && !hold_i)  cnt_o <= cnt_o + CNT_W'(1);
  end

endmodule

// File: rtl/ro_meas_fsm.sv
`timescale 1ns/1ps
module ro_meas_fsm
  import ro_meas_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ref_hit_i,
  output logic clr_o,
  output logic run_en_o,
  output logic capture_o,
  output logic ready_o,
  output logic busy_o,
  output logic hit_sync_o
);

  // clear must outlast the synchronizer so a stale hit is flushed
  localparam int unsigned CLR_CYC    = SYNC_STAGES + 1;
  localparam int unsigned SETTLE_CYC = SYNC_STAGES;
  localparam int unsigned TMR_W      = $clog2(CLR_CYC + 1);

  meas_state_t            state_q, state_d;
  logic [TMR_W-1:0]       tmr_q, tmr_d;
  logic [SYNC_STAGES-1:0] hit_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_sr <= '0;
    else        hit_sr <= {hit_sr[SYNC_STAGES-2:0], ref_hit_i};
  end
  assign hit_sync_o = hit_sr[SYNC_STAGES-1];

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        state_d = ST_CLEAR;
        tmr_d   = TMR_W'(CLR_CYC - 1);
      end
      ST_CLEAR: begin
        if (tmr_q == '0) state_d = ST_RUN;
        else             tmr_d   = tmr_q - TMR_W'(1);
      end
      ST_RUN: if (hit_sync_o) begin
        state_d = ST_SETTLE;
        tmr_d   = TMR_W'(SETTLE_CYC - 1);
      end
      ST_SETTLE: begin
        if (tmr_q == '0) state_d = ST_DONE;
        else             tmr_d   = tmr_q - TMR_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign clr_o     = (state_q == ST_CLEAR);
  assign run_en_o  = (state_q == ST_RUN);
  assign ready_o   = (state_q == ST_DONE);
  assign busy_o    = clr_o || run_en_o || (state_q == ST_SETTLE);
  assign capture_o = (state_q == ST_SETTLE) && (tmr_q == '0);

  a_r2_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en_o) |-> $past(clr_o));

  a_r5_stop_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en_o) |-> $past(hit_sync_o));

  a_r7_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !$rose(clr_o));

  a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |=> ready_o);

endmodule

// File: rtl/ro_resp_encode.sv
`timescale 1ns/1ps
module ro_resp_encode
  import ro_meas_pkg::*;
#(
  parameter int unsigned NUM_OSC   = 8,
  parameter int unsigned RESP_BITS = 4,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SEL_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture_i,
  input  logic [RESP_BITS*SEL_W-1:0] addr_i,
  input  logic [CNT_W-1:0]           cnt_i [NUM_OSC],
  input  logic [CNT_W-1:0]           ref_cnt_i,
  output logic [RESP_BITS-1:0]       response_o
);

  logic [RESP_BITS-1:0] bits_d;

  for (genvar k = 0; k < RESP_BITS; k++) begin : g_slot
    logic [SEL_W-1:0] sel;
    assign sel       = addr_i[k*SEL_W +: SEL_W];
    assign bits_d[k] = beats_ref(MAX_CNT_W'(cnt_i[sel]), MAX_CNT_W'(ref_cnt_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         response_o <= '0;
    else if (capture_i) response_o <= bits_d;
  end

  a_r8_resp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(response_o));

endmodule

// File: rtl/ro_meas_ctrl.sv
`timescale 1ns/1ps
module ro_meas_ctrl
  import ro_meas_pkg::*;
#(
  parameter int unsigned NUM_OSC   = 8,
  parameter int unsigned RESP_BITS = 4,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned SEL_W    = sel_width(NUM_OSC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_OSC-1:0]         osc_clk,
  input  logic                       start,
  input  logic [CNT_W-1:0]           obs_count,
  input  logic [SEL_W-1:0]           ref_sel,
  input  logic [RESP_BITS*SEL_W-1:0] addr,
  output logic                       run_en,
  output logic                       ready,
  output logic [RESP_BITS-1:0]       response
);

  logic [CNT_W-1:0]   cnt [NUM_OSC];
  logic [NUM_OSC-1:0] hold;
  logic [CNT_W-1:0]   ref_cnt;
  logic               ref_hit, clr, capture, busy, hit_sync;

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_chan
    // only the timebase channel halts itself at the observation count
    assign hold[i] = (ref_sel == SEL_W'(i)) && (cnt[i] == obs_count);
    ro_cnt_channel #(.CNT_W(CNT_W)) u_cnt (
      .osc_i(osc_clk[i]), .clr_i(clr), .run_en_i(run_en),
      .hold_i(hold[i]), .cnt_o(cnt[i]));
  end

  assign ref_cnt = cnt[ref_sel];
  assign ref_hit = (ref_cnt == obs_count);

  ro_meas_fsm #(.SYNC_STAGES(2)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ref_hit_i(ref_hit),
    .clr_o(clr), .run_en_o(run_en), .capture_o(capture), .ready_o(ready),
    .busy_o(busy), .hit_sync_o(hit_sync));

  ro_resp_encode #(.NUM_OSC(NUM_OSC), .RESP_BITS(RESP_BITS), .CNT_W(CNT_W),
                   .SEL_W(SEL_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .capture_i(capture), .addr_i(addr),
    .cnt_i(cnt), .ref_cnt_i(ref_cnt), .response_o(response));

  a_r4_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> (ref_cnt <= obs_count));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !run_en);

endmodule

// File: tb/tb_ro_meas_ctrl.sv
`timescale 1ns/1ps
module tb_ro_meas_ctrl;
  localparam int unsigned NO = 4, RB = 4, CW = 10, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NO-1:0]    osc;
  logic [CW-1:0]    obs_count = '0;
  logic [SW-1:0]    ref_sel = '0;
  logic [RB*SW-1:0] addr = '0;
  logic             run_en, ready;
  logic [RB-1:0]    response;
  int vectors = 0, miscompares = 0, cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic int hp(input int i);
    return 20 + 3 * i * i;
  endfunction

  for (genvar g = 0; g < NO; g++) begin : g_osc
    logic o = 1'b0;
    initial forever #(hp(g) * 1ns) o = ~o;
    assign osc[g] = o;
  end

  ro_meas_ctrl #(.NUM_OSC(NO), .RESP_BITS(RB), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc), .start(start),
    .obs_count(obs_count), .ref_sel(ref_sel), .addr(addr),
    .run_en(run_en), .ready(ready), .response(response));

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_ready(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 6000; n++) begin
      if (ready) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic measure(input int rs, input int obs, input int rot, input string tag);
    bit ok;
    logic [RB-1:0] exp_bits;
    @(negedge clk);
    ref_sel = SW'(rs);
    obs_count = CW'(obs);
    for (int k = 0; k < RB; k++) begin
      addr[k*SW +: SW] = SW'((k + rot) % NO);
      exp_bits[k] = hp((k + rot) % NO) < hp(rs);
    end
    pulse_start();
    wait_ready(ok);
    check({tag, " R5 ready"}, int'(ok), 1);
    check({tag, " R5 enable low when ready"}, int'(run_en), 0);
    check({tag, " R2 R3 R6 response"}, int'(response), int'(exp_bits));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready after reset", int'(ready), 0);
    check("R1 enable after reset", int'(run_en), 0);
    check("R1 response after reset", int'(response), 0);
    rst_n = 1'b1;

    // long count first, then short: a missing clear would leave slow channels above
    for (int rs = 0; rs < NO; rs++)
      for (int oi = 0; oi < 2; oi++)
        for (int rot = 0; rot < NO; rot++)
          measure(rs, (oi == 0) ? 100 : 40, rot, "sweep");

    // R8: result and ready held while idle
    begin
      logic [RB-1:0] held;
      held = response;
      repeat (200) @(negedge clk);
      check("R8 ready held", int'(ready), 1);
      check("R8 response held", int'(response), int'(held));
    end

    // R7: start mid-measurement is ignored
    begin
      bit ok;
      @(negedge clk);
      ref_sel = 2'd2; obs_count = CW'(100);
      for (int k = 0; k < RB; k++) addr[k*SW +: SW] = SW'(k);
      pulse_start();
      repeat (30) @(negedge clk);
      check("R7 running before extra start", int'(run_en), 1);
      pulse_start();
      check("R7 still running after extra start", int'(run_en), 1);
      wait_ready(ok);
      check("R7 ready", int'(ok), 1);
      check("R7 response", int'(response), 4'b0011);
    end

    // R9: zero observation count, every slot on the timebase
    begin
      bit ok;
      @(negedge clk);
      ref_sel = 2'd1; obs_count = '0;
      for (int k = 0; k < RB; k++) addr[k*SW +: SW] = 2'd1;
      pulse_start();
      wait_ready(ok);
      check("R9 ready", int'(ok), 1);
      check("R9 response", int'(response), 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !finished) begin
        finished = 1'b1;
        miscompares++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

endmodule